// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Double-Rate Static Memory

This block is a cycle-accurate, synthesizable model of a small static memory that has one port for reading and a separate port for writing. Each port moves data in fixed two-word bursts at double data rate. The model runs on a single clock at twice the command rate. An internal phase flag marks every other edge as a command slot, and the edge between two slots as the second-beat edge.

In a command slot, the read port samples its own address and an active-low read strobe. The write port samples its own address, an active-low write strobe, the first data beat and its active-low byte enables. The second write beat follows on the next edge. The two read words appear on a dedicated output bus one full command cycle after the read, and the second word follows half a cycle after the first. A valid flag marks the two read beats.

The two ports are independent. A read and a write can be issued in every slot, and neither port can cut short or restart a burst that is already running.

Top module: `ddr2_burst_sram`

## Requirements
- R1: During reset and in the first cycle after reset is released, `rd_valid` is 0, `rd_data` is all zeros and `beat_phase` is 0. The edge that follows is a command slot.
- R2: `beat_phase` alternates 0,1,0,1 on every clock edge, starting from reset. Strobes, addresses and write data are taken as a command only at edges where `beat_phase` is 0. A low strobe at an edge where `beat_phase` is 1 has no effect on the memory and no effect on `rd_data`.
- R3: For a read accepted at command edge E, `rd_valid` is 1 in the cycle after edge E+2 and in the cycle after edge E+3, and is 0 otherwise unless another read is running. The first read beat always begins while `beat_phase` is 1.
- R4: The first read beat carries the word at the read address. The second read beat carries the word at the read address plus one, taken modulo 2^ADDR_W.
- R5: For a write accepted at command edge E, the data and enables present at edge E go to the write address. The data and enables present at edge E+1 go to the write address plus one, taken modulo 2^ADDR_W.
- R6: `wr_be_n[i]` controls byte lane i, which is bits 8i+7 down to 8i of `wr_data`. It applies separately to each beat. Only lanes whose enable is 0 are updated. Lanes whose enable is 1 keep their old value.
- R7: A read returns the memory contents as left by every write accepted in an earlier command slot. A write accepted in the same slot as the read is not seen by that read, even when the addresses overlap.
- R8: A read and a write may be accepted in every command slot. When reads are issued in consecutive slots, `rd_valid` stays 1 and the beats follow each other without gaps.
- R9: A command slot with both strobes high changes no memory word, whatever the data and enables are. Whenever `rd_valid` is 0, `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; every other rising edge is a command slot |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe, sampled in command slots |
| rd_addr | input | ADDR_W | Read burst start address |
| wr_n | input | 1 | Active-low write strobe, sampled in command slots |
| wr_addr | input | ADDR_W | Write burst start address |
| wr_data | input | DATA_W | Write data for the current beat |
| wr_be_n | input | DATA_W/8 | Active-low byte enables for the current beat |
| rd_data | output | DATA_W | Read data beat, zero when idle |
| rd_valid | output | 1 | High while a read beat is on `rd_data` |
| beat_phase | output | 1 | 0 at command-slot edges, 1 at second-beat edges |

## Verification
The bench builds the block with ADDR_W=4 and DATA_W=16. With sixteen words, a burst that starts at the last address and wraps to address zero can be reached in a few cycles. With two byte lanes, mixed per-beat enable patterns are possible, such as updating only the upper byte on the first beat and only the lower byte on the second. The small depth also makes it cheap to fill and read back the whole array. It also lets a stream of concurrent reads and writes overlap on shared words, so that the ordering between a read and a write in the same slot is exercised.

// File: rtl/ddr2_b2_pkg.sv
// Package: shared constants and types for the burst-of-two dual-port memory.
// Assumes: data words are a whole number of 8-bit lanes.
package ddr2_b2_pkg;
    localparam int unsigned LANE_W = 8;

    // Phase of the double-rate clock: command slot or second beat.
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_BEAT = 1'b1
    } phase_e;
endpackage

// File: rtl/ddr2_b2_phase_gen.sv
// Module: ddr2_b2_phase_gen
// Divides the double-rate clock into command slots and second-beat edges.
// Assumes: reset is synchronous and active low; the first edge after reset
// is a command slot.
module ddr2_b2_phase_gen
    import ddr2_b2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic cmd_slot,
    output logic phase_bit
);
    phase_e phase_q;

    // Toggle the phase on every edge, starting from the command phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CMD;
        end else begin
            phase_q <= (phase_q == PH_CMD) ? PH_BEAT : PH_CMD;
        end
    end

    // The current edge is a command slot while the phase is PH_CMD.
    always_comb begin
        cmd_slot  = (phase_q == PH_CMD);
        phase_bit = phase_q;
    end

    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        phase_bit |=> !phase_bit); // R2
endmodule

// File: rtl/ddr2_b2_store.sv
// Module: ddr2_b2_store
// Word array with one byte-masked write port and two asynchronous read ports.
// Assumes: one write at most per edge; the contents are not reset.
module ddr2_b2_store
    import ddr2_b2_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W/LANE_W-1:0]   wbe_n,
    input  logic [ADDR_W-1:0]          ra0,
    input  logic [ADDR_W-1:0]          ra1,
    output logic [DATA_W-1:0]          rd0,
    output logic [DATA_W-1:0]          rd1
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] bit_mask;

    // Spread each active-low lane enable over the bits of its lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{~wbe_n[g]}};
    end

    // Merge the enabled lanes into the addressed word.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= (mem[waddr] & ~bit_mask) | (wdata & bit_mask);
        end
    end

    // The read ports see the contents as they were before the current edge.
    always_comb begin
        rd0 = mem[ra0];
        rd1 = mem[ra1];
    end
endmodule

// File: rtl/ddr2_b2_write_port.sv
// Module: ddr2_b2_write_port
// Turns a write command into two array writes on consecutive edges: the
// command address at the slot edge, then the address plus one at the
// second-beat edge.
// Assumes: commands are honoured only when cmd_slot is high.
module ddr2_b2_write_port
    import ddr2_b2_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_slot,
    input  logic                       wr_n,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [DATA_W/LANE_W-1:0]   wr_be_n,
    output logic                       we,
    output logic [ADDR_W-1:0]          waddr,
    output logic [DATA_W-1:0]          wdata,
    output logic [DATA_W/LANE_W-1:0]   wbe_n
);
    logic              accept;
    logic              b1_pend;
    logic [ADDR_W-1:0] b1_addr;

    assign accept = cmd_slot && !wr_n;

    // Remember the second-beat address for the edge after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b1_pend <= 1'b0;
            b1_addr <= '0;
        end else begin
            b1_pend <= accept;
            if (accept) begin
                b1_addr <= wr_addr + 1'b1;
            end
        end
    end

    // Choose which beat, if any, writes the array on this edge.
    always_comb begin
        we    = 1'b0;
        waddr = wr_addr;
        wdata = wr_data;
        wbe_n = wr_be_n;
        if (accept) begin
            we    = 1'b1;
            waddr = wr_addr;
        end else if (b1_pend) begin
            we    = 1'b1;
            waddr = b1_addr;
        end
    end

    AST_BEAT1_OFF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        b1_pend |-> !cmd_slot); // R5
endmodule

// File: rtl/ddr2_b2_read_port.sv
// Module: ddr2_b2_read_port
// Captures both burst words in the command slot, then presents them on
// the two edges of the following command cycle.
// Assumes: the array read ports give the contents as of before the edge,
// so a write in the same slot is not seen.
module ddr2_b2_read_port #(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_slot,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd0,
    input  logic [DATA_W-1:0] rd1,
    output logic [ADDR_W-1:0] ra0,
    output logic [ADDR_W-1:0] ra1,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              s1_v, s2_v;
    logic [DATA_W-1:0] s1_w0, s1_w1, s2_w0, s2_w1;

    // Address both words of the burst directly from the command inputs.
    always_comb begin
        ra0 = rd_addr;
        ra1 = rd_addr + 1'b1;
    end

    // Capture in the slot, move forward at the second beat, drive both beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_w0    <= '0;
            s1_w1    <= '0;
            s2_v     <= 1'b0;
            s2_w0    <= '0;
            s2_w1    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (cmd_slot) begin
            s1_v <= !rd_n;
            if (!rd_n) begin
                s1_w0 <= rd0;
                s1_w1 <= rd1;
            end
            rd_valid <= s2_v;
            rd_data  <= s2_v ? s2_w0 : '0;
        end else begin
            s2_v     <= s1_v;
            s2_w0    <= s1_w0;
            s2_w1    <= s1_w1;
            rd_valid <= s2_v;
            rd_data  <= s2_v ? s2_w1 : '0;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R9
    AST_FIRST_BEAT_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> !cmd_slot); // R3
    AST_SECOND_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !cmd_slot) |=> rd_valid); // R3
endmodule

// File: rtl/ddr2_burst_sram.sv
// Module: ddr2_burst_sram
// Top of the burst-of-two memory with separate read and write ports.
// Assumes: clk runs at twice the command rate; beat_phase tells the
// environment which edges are command slots.
module ddr2_burst_sram
    import ddr2_b2_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_n,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic                     wr_n,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/LANE_W-1:0] wr_be_n,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid,
    output logic                     beat_phase
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    logic              cmd_slot;
    logic              we;
    logic [ADDR_W-1:0] waddr, ra0, ra1;
    logic [DATA_W-1:0] wdata, rd0, rd1;
    logic [LANES-1:0]  wbe_n;

    ddr2_b2_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_slot  (cmd_slot),
        .phase_bit (beat_phase)
    );

    ddr2_b2_write_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wport (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_slot (cmd_slot),
        .wr_n     (wr_n),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_be_n  (wr_be_n),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .wbe_n    (wbe_n)
    );

    ddr2_b2_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .wbe_n (wbe_n),
        .ra0   (ra0),
        .ra1   (ra1),
        .rd0   (rd0),
        .rd1   (rd1)
    );

    ddr2_b2_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rport (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_slot (cmd_slot),
        .rd_n     (rd_n),
        .rd_addr  (rd_addr),
        .rd0      (rd0),
        .rd1      (rd1),
        .ra0      (ra0),
        .ra1      (ra1),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !beat_phase)); // R1
endmodule

// File: tb/test_ddr2_burst_sram.sv
`timescale 1ns/1ps
module test_ddr2_burst_sram;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int LN  = DW / 8;
    localparam int DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          wr_n = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [LN-1:0] wr_be_n = '1;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          beat_phase;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit chk_on = 1'b0;
    bit noise  = 1'b0;
    bit done   = 1'b0;

    logic [DW-1:0] ref_mem [DEP];
    logic          exp_v [8];
    logic [DW-1:0] exp_d [8];
    string         exp_tag [8];

    always #2 clk = ~clk;

    ddr2_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) i_ddr2_burst_sram (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_addr(rd_addr),
        .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be_n(wr_be_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .beat_phase(beat_phase)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Compare the read outputs with the scheduled expectation every cycle.
    always @(negedge clk) begin
        if (chk_on) begin
            automatic int i = cyc % 8;
            automatic logic [DW-1:0] want = exp_v[i] ? exp_d[i] : '0;
            checks++;
            if (rd_valid !== exp_v[i] || rd_data !== want) begin
                fails++;
                $display("FAIL %s: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h",
                         exp_tag[i], rd_valid, rd_data, exp_v[i], want);
            end
            exp_v[i]   = 1'b0;
            exp_d[i]   = '0;
            exp_tag[i] = "R9 idle output";
        end
    end

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] d,
                                            input logic [LN-1:0] be_n);
        logic [DW-1:0] r = old;
        for (int l = 0; l < LN; l++) if (!be_n[l]) r[l*8 +: 8] = d[l*8 +: 8];
        return r;
    endfunction

    // One command slot plus its second-beat cycle; called at a slot negedge.
    task automatic slot(input logic r_n, input logic [AW-1:0] ra,
                        input logic w_n, input logic [AW-1:0] wa,
                        input logic [DW-1:0] d0, input logic [LN-1:0] b0,
                        input logic [DW-1:0] d1, input logic [LN-1:0] b1,
                        input string tag);
        logic [AW-1:0] ra1 = ra + 1'b1;
        logic [AW-1:0] wa1 = wa + 1'b1;
        checks++;
        if (beat_phase !== 1'b0) begin
            fails++;
            $display("FAIL R2 slot phase: beat_phase=%0b expected 0", beat_phase);
        end
        rd_n = r_n; rd_addr = ra; wr_n = w_n; wr_addr = wa;
        wr_data = d0; wr_be_n = b0;
        if (!r_n) begin
            exp_v[(cyc+3)%8] = 1'b1; exp_d[(cyc+3)%8] = ref_mem[ra];  exp_tag[(cyc+3)%8] = tag;
            exp_v[(cyc+4)%8] = 1'b1; exp_d[(cyc+4)%8] = ref_mem[ra1]; exp_tag[(cyc+4)%8] = tag;
        end
        if (!w_n) begin
            ref_mem[wa]  = merge(ref_mem[wa], d0, b0);
            ref_mem[wa1] = merge(ref_mem[wa1], d1, b1);
        end
        @(negedge clk);
        wr_data = d1; wr_be_n = b1;
        if (noise) begin
            rd_n = 1'b0; wr_n = 1'b0; rd_addr = ra + 4'd3; wr_addr = wa + 4'd5;
        end else begin
            rd_n = 1'b1; wr_n = 1'b1;
        end
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1; wr_be_n = '1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) slot(1, 0, 1, 0, 16'h0, '1, 16'h0, '1, "R9 idle");
    endtask

    task automatic t_reset();
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== '0 || beat_phase !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: valid=%0b data=%h phase=%0b expected 0 0000 0",
                     rd_valid, rd_data, beat_phase);
        end
    endtask

    task automatic t_fill();
        for (int a = 0; a < DEP; a += 2)
            slot(1, 0, 0, AW'(a), 16'hA000 + 16'(a), 2'b00, 16'h5100 + 16'(a), 2'b00, "R5 fill");
        for (int a = 0; a < DEP; a += 2) slot(0, AW'(a), 1, 0, 0, '1, 0, '1, "R3 R4 readback");
        for (int a = 1; a < DEP; a += 4) slot(0, AW'(a), 1, 0, 0, '1, 0, '1, "R4 odd start");
        idle(2);
    endtask

    task automatic t_wrap();
        slot(1, 0, 0, AW'(DEP-1), 16'hBEEF, 2'b00, 16'hCAFE, 2'b00, "R5 wrap write");
        slot(0, AW'(DEP-1), 1, 0, 0, '1, 0, '1, "R4 R5 wrap read");
        idle(2);
    endtask

    task automatic t_bytes();
        slot(1, 0, 0, 4'd6, 16'h1122, 2'b01, 16'h3344, 2'b10, "R6 lanes");
        slot(1, 0, 0, 4'd9, 16'h7788, 2'b11, 16'h99AA, 2'b00, "R6 lanes");
        slot(0, 4'd6, 1, 0, 0, '1, 0, '1, "R6 lane readback");
        slot(0, 4'd9, 1, 0, 0, '1, 0, '1, "R6 lane readback");
        idle(2);
    endtask

    task automatic t_rbw();
        slot(0, 4'd4, 0, 4'd4, 16'hD0D0, 2'b00, 16'hD1D1, 2'b00, "R7 same slot old data");
        slot(0, 4'd4, 1, 0, 0, '1, 0, '1, "R7 next slot new data");
        slot(1, 0, 0, 4'd11, 16'hE0E0, 2'b00, 16'hE1E1, 2'b00, "R7 write");
        slot(0, 4'd12, 0, 4'd12, 16'hF0F0, 2'b10, 16'hF1F1, 2'b01, "R7 overlap second beat");
        slot(0, 4'd11, 1, 0, 0, '1, 0, '1, "R7 after");
        idle(2);
    endtask

    task automatic t_stream();
        for (int k = 0; k < 10; k++)
            slot(0, AW'(k), 0, AW'(k + 6), 16'h6000 + 16'(k), 2'b00,
                 16'h6800 + 16'(k), 2'b00, "R8 stream");
        idle(2);
    endtask

    task automatic t_deselect();
        for (int k = 0; k < 4; k++)
            slot(1, AW'(k), 1, AW'(2*k), 16'hFFFF, 2'b00, 16'hFFFF, 2'b00, "R9 deselect");
        for (int a = 0; a < 8; a += 2) slot(0, AW'(a), 1, 0, 0, '1, 0, '1, "R9 unchanged");
        idle(2);
    endtask

    task automatic t_phase_noise();
        noise = 1'b1;
        idle(4);
        slot(0, 4'd2, 1, 0, 0, '1, 0, '1, "R2 odd edge strobe read");
        noise = 1'b0;
        idle(2);
        for (int a = 0; a < DEP; a += 2) slot(0, AW'(a), 1, 0, 0, '1, 0, '1, "R2 odd edge no write");
        idle(2);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin exp_v[i] = 0; exp_d[i] = '0; exp_tag[i] = "R9 idle output"; end
        for (int i = 0; i < DEP; i++) ref_mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        chk_on = 1'b1;
        t_fill();
        t_wrap();
        t_bytes();
        t_rbw();
        t_stream();
        t_deselect();
        t_phase_noise();
        chk_on = 1'b0;
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
            $finish;
        end
    end
endmodule